// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block stands in for the device side of a serial keyboard as seen by a host. The host writes bytes into the transmit data path. While transmit is enabled, each accepted byte is read as a keyboard command. The block answers some commands by loading fixed response bytes into a small circular receive queue. Key make and break events arrive on a separate event port. They pass through a lock-key filter and are then queued as keycodes. The host drains the queue through a read port, one byte per handshake.

The command port and the key-event port share the queue's single write port. A command response always owns that port first. A key event that has been accepted waits in a one-entry holding register until the port is free. Commands answer in several cycles, one response byte per cycle, and `cmd_ready` stays low while a response is being written. A data byte that follows the LED command is latched on `led_byte` and is not treated as a command.

Back-pressure rules: a byte on `cmd_data` moves when `cmd_valid` and `cmd_ready` are both high at a clock edge. A key event moves when `key_valid` and `key_ready` are both high. A queue byte is popped when `rd_ready` is high while `rd_valid` is high. A source must keep its data stable while its valid is high and its ready is low.

Top module: `kbd_responder`

## Requirements
- R1: After reset `rd_valid` is 0, `rd_data` is 0x00, `cmd_ready` and `key_ready` are 1, `led_byte` is 0x00, and the LED-pending flag and both lock modes are clear.
- R2: An accepted command 0x01, taken with `tx_en` high and no LED byte pending, empties the queue and then writes 0xFF, 0x04 and 0x7F in that order. It writes one byte per cycle, and `cmd_ready` stays low for those three cycles.
- R3: An accepted command 0x07 or 0x0F empties the queue and then writes 0xFE followed by 0x21.
- R4: An accepted command 0x0E sets the LED-pending flag. The next byte accepted with `tx_en` high is copied to `led_byte`, is not decoded as a command, and clears the flag.
- R5: Any other command value has no effect on the queue or on `led_byte`. The same holds for every byte accepted while `tx_en` is low, and such a byte leaves the LED-pending flag as it was.
- R6: A key event queues `{key_release, key_code[6:0]}`, so bit 7 is set for a release and clear for a press. `key_kind` uses 2'b00 for a plain key, 2'b01 for caps lock, 2'b10 for num lock, and 2'b11 is treated as plain.
- R7: Caps lock and num lock each keep a 2-bit mode that starts at 0. A press flips bit 0 and a release flips bit 1. A press that leaves the mode at 2 is dropped, and so is a release that leaves it at 3. As a result, press, release, press, release produces only the first press and the last release.
- R8: The queue holds DEPTH bytes (default 16). A byte written while DEPTH bytes are already stored is discarded, even if a pop happens in the same cycle.
- R9: `rd_valid` is high exactly while the queue is not empty, and `rd_data` shows the oldest byte. A pop with bytes still left raises `rd_valid` again for the next byte. When the queue is empty `rd_data` is 0x00 and `rd_ready` has no effect.
- R10: When a command and a key event are accepted at the same edge, the command's response bytes go into the queue first. The key byte is held and written after them, and `key_ready` is low while the held byte waits behind a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; host bytes are interpreted only while high |
| cmd_valid | input | 1 | Host byte is offered |
| cmd_ready | output | 1 | Block can accept a host byte |
| cmd_data | input | 8 | Host command or LED byte |
| key_valid | input | 1 | Key event is offered |
| key_ready | output | 1 | Block can accept a key event |
| key_code | input | 7 | Keycode of the event |
| key_release | input | 1 | 1 for release, 0 for press |
| key_kind | input | 2 | 00 plain, 01 caps lock, 10 num lock, 11 plain |
| rd_valid | output | 1 | Queue holds at least one byte |
| rd_ready | input | 1 | Host pops the head byte |
| rd_data | output | 8 | Head byte, or 0x00 when the queue is empty |
| led_byte | output | 8 | Last LED data byte latched |

## Verification
The reset and layout commands are sent while the queue already holds key bytes. This shows whether the queue is emptied before the response is written, as opposed to the response being added to what was there. Lock keys are driven with four-step press/release runs, next to plain keys with the same code. A wrong mode update then shows up as an extra or a missing byte. The queue is overfilled and then drained past empty to test both the discard rule and the zero return value. A command and a key event are offered in the same cycle to expose the write order. A long random mix of commands, tx-disabled bytes, LED sequences, key events and pops is compared against a byte-level model of the queue.

// File: rtl/kbd_pkg.sv
`timescale 1ns/1ps
package kbd_pkg;

  typedef enum logic [1:0] {
    RESP_NONE   = 2'd0,
    RESP_RESET  = 2'd1,
    RESP_LAYOUT = 2'd2
  } resp_e;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'b00,
    KIND_CAPS  = 2'b01,
    KIND_NUM   = 2'b10,
    KIND_ALT   = 2'b11
  } key_kind_e;

  localparam logic [7:0] CMD_RESET   = 8'h01;
  localparam logic [7:0] CMD_LAYOUTA = 8'h07;
  localparam logic [7:0] CMD_LEDSET  = 8'h0E;
  localparam logic [7:0] CMD_LAYOUTB = 8'h0F;

  localparam int NUM_LOCKS = 2;

  function automatic logic [1:0] resp_len(resp_e k);
    case (k)
      RESP_RESET:  return 2'd3;
      RESP_LAYOUT: return 2'd2;
      default:     return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] resp_byte(resp_e k, logic [1:0] idx);
    logic [7:0] b;
    b = 8'h00;
    if (k == RESP_RESET) begin
      case (idx)
        2'd0:    b = 8'hFF;
        2'd1:    b = 8'h04;
        default: b = 8'h7F;
      endcase
    end else if (k == RESP_LAYOUT) begin
      b = (idx == 2'd0) ? 8'hFE : 8'h21;
    end
    return b;
  endfunction

endpackage

// File: rtl/kbd_byte_fifo.sv
`timescale 1ns/1ps
module kbd_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop_req,
  output logic [DW-1:0]                head,
  output logic                         not_empty,
  output logic [$clog2(DEPTH+1)-1:0]   fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [FW-1:0] FULL = FW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [FW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign do_push   = push && (clr || (cnt != FULL));
  assign do_pop    = pop_req && (cnt != '0) && !clr;
  assign not_empty = (cnt != '0);
  assign head      = not_empty ? mem[rptr] : '0;
  assign fill      = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else if (clr) begin
      rptr <= '0;
      wptr <= push ? bump('0) : '0;
      cnt  <= push ? FW'(1) : '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + FW'(1);
        2'b01:   cnt <= cnt - FW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      if (clr) mem[0] <= push_data;
      else     mem[wptr] <= push_data;
    end
  end

endmodule

// File: rtl/kbd_cmd_engine.sv
`timescale 1ns/1ps
module kbd_cmd_engine
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_data,
  output logic       emit_valid,
  output logic       emit_clear,
  output logic [7:0] emit_data,
  output logic       led_pending,
  output logic [7:0] led_byte
);
  resp_e      kind;
  logic [1:0] idx;
  logic       busy;
  logic       led_pend_q;
  logic [7:0] led_q;
  logic       take;

  assign cmd_ready   = !busy;
  assign take        = cmd_valid && !busy && tx_en;
  assign emit_valid  = busy;
  assign emit_clear  = busy && (idx == 2'd0);
  assign emit_data   = resp_byte(kind, idx);
  assign led_pending = led_pend_q;
  assign led_byte    = led_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      kind       <= RESP_NONE;
      idx        <= 2'd0;
      led_pend_q <= 1'b0;
      led_q      <= 8'h00;
    end else begin
      if (busy) begin
        if (idx == resp_len(kind) - 2'd1) begin
          busy <= 1'b0;
          idx  <= 2'd0;
          kind <= RESP_NONE;
        end else begin
          idx <= idx + 2'd1;
        end
      end
      if (take) begin
        if (led_pend_q) begin
          led_q      <= cmd_data;
          led_pend_q <= 1'b0;
        end else begin
          case (cmd_data)
            CMD_RESET: begin
              busy <= 1'b1;
              kind <= RESP_RESET;
              idx  <= 2'd0;
            end
            CMD_LAYOUTA, CMD_LAYOUTB: begin
              busy <= 1'b1;
              kind <= RESP_LAYOUT;
              idx  <= 2'd0;
            end
            CMD_LEDSET: led_pend_q <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/kbd_lock_filter.sv
`timescale 1ns/1ps
module kbd_lock_filter
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_fire,
  input  logic [6:0] ev_code,
  input  logic       ev_release,
  input  logic [1:0] ev_kind,
  output logic       ev_pass,
  output logic [7:0] ev_keycode
);
  logic [1:0] mode     [NUM_LOCKS];
  logic [1:0] mode_nxt [NUM_LOCKS];
  logic [NUM_LOCKS-1:0] hit;
  logic [NUM_LOCKS-1:0] drop;

  assign ev_keycode = {ev_release, ev_code};

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    always_comb begin
      hit[g]      = (ev_kind == ((g == 0) ? KIND_CAPS : KIND_NUM));
      mode_nxt[g] = ev_release ? (mode[g] ^ 2'b10) : (mode[g] ^ 2'b01);
      drop[g]     = hit[g] && (ev_release ? (mode_nxt[g] == 2'd3)
                                          : (mode_nxt[g] == 2'd2));
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                mode[g] <= 2'd0;
      else if (ev_fire && hit[g]) mode[g] <= mode_nxt[g];
    end
  end

  assign ev_pass = (drop == '0);

endmodule

// File: rtl/kbd_responder.sv
`timescale 1ns/1ps
module kbd_responder
  import kbd_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_data,
  input  logic       key_valid,
  output logic       key_ready,
  input  logic [6:0] key_code,
  input  logic       key_release,
  input  logic [1:0] key_kind,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic [7:0] led_byte
);
  localparam int FW = $clog2(DEPTH+1);

  logic          emit_valid, emit_clear;
  logic [7:0]    emit_data;
  logic          led_pending;
  logic          key_fire, ev_pass;
  logic [7:0]    ev_keycode;
  logic          kh_valid, kh_go;
  logic [7:0]    kh_data;
  logic          q_push, q_clear;
  logic [7:0]    q_data;
  logic [FW-1:0] q_fill;

  kbd_cmd_engine u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_data    (cmd_data),
    .emit_valid  (emit_valid),
    .emit_clear  (emit_clear),
    .emit_data   (emit_data),
    .led_pending (led_pending),
    .led_byte    (led_byte)
  );

  assign kh_go     = kh_valid && !emit_valid;
  assign key_ready = !kh_valid || kh_go;
  assign key_fire  = key_valid && key_ready;

  kbd_lock_filter u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_fire    (key_fire),
    .ev_code    (key_code),
    .ev_release (key_release),
    .ev_kind    (key_kind),
    .ev_pass    (ev_pass),
    .ev_keycode (ev_keycode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kh_valid <= 1'b0;
      kh_data  <= 8'h00;
    end else if (key_fire) begin
      kh_valid <= ev_pass;
      kh_data  <= ev_keycode;
    end else if (kh_go) begin
      kh_valid <= 1'b0;
    end
  end

  assign q_clear = emit_clear;
  assign q_push  = emit_valid || kh_go;
  assign q_data  = emit_valid ? emit_data : kh_data;

  kbd_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (q_clear),
    .push      (q_push),
    .push_data (q_data),
    .pop_req   (rd_ready),
    .head      (rd_data),
    .not_empty (rd_valid),
    .fill      (q_fill)
  );

endmodule

// File: rtl/kbd_responder_chk.sv
`timescale 1ns/1ps
module kbd_responder_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tx_en,
  input logic                       cmd_valid,
  input logic                       cmd_ready,
  input logic [7:0]                 cmd_data,
  input logic [7:0]                 led_byte,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic [7:0]                 rd_data,
  input logic [$clog2(DEPTH+1)-1:0] q_fill,
  input logic                       q_clear,
  input logic                       kh_valid,
  input logic                       emit_valid,
  input logic                       led_pending
);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_fill <= ($clog2(DEPTH+1))'(DEPTH));

  assert_empty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == 8'h00);

  assert_next_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_fill > 1 && rd_valid && rd_ready && !q_clear) |=> rd_valid);

  assert_reset_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && tx_en && !led_pending && cmd_data == 8'h01)
      |=> (!cmd_ready && q_clear));

  assert_txoff_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !tx_en) |=> ($stable(led_byte) && cmd_ready));

  assert_key_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (kh_valid && emit_valid) |=> kh_valid);

endmodule

bind kbd_responder kbd_responder_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_data    (cmd_data),
  .led_byte    (led_byte),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data),
  .q_fill      (q_fill),
  .q_clear     (q_clear),
  .kh_valid    (kh_valid),
  .emit_valid  (emit_valid),
  .led_pending (led_pending)
);

// File: tb/kbd_responder_tb.sv
`timescale 1ns/1ps
module kbd_responder_tb;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = 8'h00;
  logic       key_valid = 1'b0;
  logic       key_ready;
  logic [6:0] key_code = 7'h00;
  logic       key_release = 1'b0;
  logic [1:0] key_kind = 2'b00;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] led_byte;

  int checks = 0;
  int failures = 0;

  byte unsigned mq[$];
  logic [7:0] led_exp = 8'h00;
  logic       ledp = 1'b0;
  logic [1:0] lmode [2] = '{2'd0, 2'd0};

  always #2.5 clk = ~clk;

  kbd_responder #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .key_valid(key_valid), .key_ready(key_ready), .key_code(key_code),
    .key_release(key_release), .key_kind(key_kind),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .led_byte(led_byte)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void mpush(byte unsigned b);
    if (mq.size() < DEPTH) mq.push_back(b);
  endfunction

  function automatic void model_cmd(logic [7:0] b, logic en);
    if (!en) return;
    if (ledp) begin
      led_exp = b;
      ledp = 1'b0;
    end else begin
      case (b)
        8'h01: begin mq.delete(); mpush(8'hFF); mpush(8'h04); mpush(8'h7F); end
        8'h07, 8'h0F: begin mq.delete(); mpush(8'hFE); mpush(8'h21); end
        8'h0E: ledp = 1'b1;
        default: ;
      endcase
    end
  endfunction

  function automatic void model_key(logic [6:0] c, logic rel, logic [1:0] k);
    logic [1:0] n;
    int li;
    li = (k == 2'b01) ? 0 : (k == 2'b10) ? 1 : -1;
    if (li >= 0) begin
      n = rel ? (lmode[li] ^ 2'b10) : (lmode[li] ^ 2'b01);
      lmode[li] = n;
      if (rel && n == 2'd3) return;
      if (!rel && n == 2'd2) return;
    end
    mpush({rel, c});
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] b, input logic en);
    @(negedge clk);
    tx_en = en; cmd_data = b; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    model_cmd(b, en);
    settle(5);
  endtask

  task automatic send_key(input logic [6:0] c, input logic rel, input logic [1:0] k);
    @(negedge clk);
    key_code = c; key_release = rel; key_kind = k; key_valid = 1'b1;
    while (!key_ready) @(negedge clk);
    @(negedge clk);
    key_valid = 1'b0;
    model_key(c, rel, k);
    settle(2);
  endtask

  task automatic pop_one(input string req);
    byte unsigned e;
    e = (mq.size() != 0) ? mq[0] : 8'h00;
    chk(rd_valid, mq.size() != 0, req);
    chk(rd_data, e, req);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    if (mq.size() != 0) void'(mq.pop_front());
  endtask

  task automatic drain(input string req);
    while (mq.size() != 0) pop_one(req);
    pop_one(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_valid, 0, "R1");
    chk(rd_data, 8'h00, "R1");
    chk(cmd_ready, 1, "R1");
    chk(key_ready, 1, "R1");
    chk(led_byte, 8'h00, "R1");

    // R2 reset command and its busy window
    @(negedge clk);
    tx_en = 1'b1; cmd_data = 8'h01; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready, 0, "R2 busy1");
    @(negedge clk);
    chk(cmd_ready, 0, "R2 busy2");
    @(negedge clk);
    chk(cmd_ready, 0, "R2 busy3");
    @(negedge clk);
    chk(cmd_ready, 1, "R2 done");
    model_cmd(8'h01, 1'b1);
    drain("R2");

    // R3 layout query clears earlier key bytes
    send_key(7'h11, 1'b0, 2'b00);
    send_key(7'h22, 1'b1, 2'b00);
    send_cmd(8'h07, 1'b1);
    chk(mq.size(), 2, "R3 model");
    drain("R3 0x07");
    send_key(7'h33, 1'b0, 2'b00);
    send_cmd(8'h0F, 1'b1);
    drain("R3 0x0F");

    // R4 LED byte swallows a command value
    send_cmd(8'h0E, 1'b1);
    send_cmd(8'h01, 1'b1);
    chk(led_byte, led_exp, "R4 led");
    chk(rd_valid, 0, "R4 not decoded");
    send_cmd(8'h0E, 1'b1);
    send_cmd(8'h5A, 1'b0);
    send_cmd(8'hC3, 1'b1);
    chk(led_byte, 8'hC3, "R5 txoff keeps pending / R4");

    // R5 ignored values and tx disabled
    send_key(7'h05, 1'b0, 2'b00);
    send_cmd(8'h55, 1'b1);
    send_cmd(8'h01, 1'b0);
    send_cmd(8'h0E, 1'b0);
    send_cmd(8'h07, 1'b1);
    chk(rd_data, 8'hFE, "R5 0x0E with tx off not latched");
    drain("R5");

    // R6 / R7 lock filtering next to plain keys
    for (int i = 0; i < 4; i++) send_key(7'h77, i[0], 2'b01);
    for (int i = 0; i < 4; i++) send_key(7'h62, i[0], 2'b10);
    send_key(7'h2A, 1'b1, 2'b11);
    chk(mq.size(), 5, "R7 model count");
    drain("R6 R7");

    // R8 overfill then drain past empty
    for (int i = 0; i < DEPTH + 4; i++) send_key(7'(i), 1'b0, 2'b00);
    chk(mq.size(), DEPTH, "R8 model");
    drain("R8 R9");
    pop_one("R9 empty pop");

    // R10 simultaneous command and key
    @(negedge clk);
    tx_en = 1'b1; cmd_data = 8'h01; cmd_valid = 1'b1;
    key_code = 7'h3C; key_release = 1'b0; key_kind = 2'b00; key_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; key_valid = 1'b0;
    chk(key_ready, 0, "R10 key held");
    model_cmd(8'h01, 1'b1);
    model_key(7'h3C, 1'b0, 2'b00);
    settle(6);
    drain("R10 order");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 3) begin
        logic [7:0] b;
        int r;
        r = int'($urandom_range(0, 5));
        b = (r == 0) ? 8'h01 : (r == 1) ? 8'h07 : (r == 2) ? 8'h0F :
            (r == 3) ? 8'h0E : 8'($urandom);
        send_cmd(b, ($urandom_range(0, 3) != 0));
        chk(led_byte, led_exp, "R4 R5 random");
      end else if (sel < 7) begin
        send_key(7'($urandom), 1'($urandom), 2'($urandom));
      end else begin
        pop_one("R9 random");
      end
    end
    drain("R8 R9 final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule